// File: doc/BRIEF.md
# Detector Interlock and Output Gating

This block keeps the safety interlock state for a crate of 16 detector channels and gates their ON/OFF enables. A detector may be powered only when the external relay contacts are closed and an operator has then acknowledged. The acknowledge can come from software or from a front-panel button, which is debounced before it reaches this block. At reset the block is interlocked. Any opening of the relay puts it back into the interlocked state, and a new acknowledge is then needed.

The per-channel enable mask arrives from a configuration register outside the block. Gating happens at the output only, so the register contents are never touched. Once the interlock clears, the detectors return to the configured pattern with no rewrite.

The relay input passes through a synchroniser. A relay opening takes effect at once. A relay closing counts only after the contacts have stayed closed for a qualification window of `HOLD_CYCLES` clocks, which is one millisecond at the nominal clock.

Top module: `det_interlock`

## Requirements
- R1: After reset deassertion `ilk_o` and `led_o` are 1 and `det_en_o` is all zeros, whatever the mask.
- R2: While `ilk_o` is 1, every bit of `det_en_o` is 0 for any value of `det_mask_i`.
- R3: While `ilk_o` is 0, bit i of `det_en_o` equals bit i of `det_mask_i` for every channel i, with no register in that path.
- R4: An acknowledge (software or button) given while the relay is open leaves the block interlocked.
- R5: A relay close is accepted only after `relay_closed_i` has been 1 without a break for `HOLD_CYCLES` clocks after synchronisation. An acknowledge before that point is ignored and is not remembered.
- R6: A software acknowledge pulse (`ack_sw_i`=1 for one clock) while the close is accepted clears `ilk_o` on that clock edge.
- R7: A button acknowledge (`ack_btn_i`=1 for one clock) while the close is accepted clears `ilk_o` on that clock edge.
- R8: A 0 on `relay_closed_i` sets `ilk_o` no more than three clock edges later, including a one-clock opening. After the relay closes again, the block stays interlocked until a new acknowledge.
- R9: After the block re-enters the interlock and is acknowledged again, `det_en_o` returns to the unchanged `det_mask_i` with no other action.
- R10: `led_o` always equals `ilk_o`, and 1 means interlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| relay_closed_i | input | 1 | External relay contacts, 1 = closed, asynchronous |
| ack_sw_i | input | 1 | Software acknowledge pulse |
| ack_btn_i | input | 1 | Debounced front-panel acknowledge |
| det_mask_i | input | N_CH | Configured detector enables, 1 = ON |
| ilk_o | output | 1 | Interlock status, 1 = interlocked |
| led_o | output | 1 | Front-panel interlock LED drive |
| det_en_o | output | N_CH | Gated detector enables |

## Verification
The bench gives an acknowledge before the qualification window has run out. A design that latched that early acknowledge, or cleared the interlock with the relay barely closed, would turn the detectors on too soon. It also opens the relay for a single clock. A design that filtered that opening, or that remembered the previous acknowledge, would stay unlocked without a new operator action. Walking-one and pseudo-random masks are run in both states to catch a gate that leaks while locked, drops or swaps channels while unlocked, or loses the configuration over an interlock cycle.

// File: rtl/det_ilk_pkg.sv
package det_ilk_pkg;
  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_LOCKED = 1'b1
  } ilk_state_e;
endpackage

// File: rtl/ilk_relay_sync.sv
module ilk_relay_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ilk_relay_qual.sv
module ilk_relay_qual #(
  parameter int unsigned HOLD_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic closed_i,
  output logic closed_ok_o
);
  localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  // any open clears progress at once; a close counts up to the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!closed_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == LAST) ok_q  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign closed_ok_o = ok_q;
endmodule

// File: rtl/ilk_state_fsm.sv
module ilk_state_fsm
  import det_ilk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic closed_sync_i,
  input  logic closed_ok_i,
  input  logic ack_i,
  output logic locked_o
);
  ilk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!closed_sync_i)           state_d = ST_LOCKED;
    else if (closed_ok_i && ack_i) state_d = ST_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOCKED;
    else         state_q <= state_d;
  end

  assign locked_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/ilk_out_gate.sv
module ilk_out_gate #(
  parameter int unsigned N_CH = 16
) (
  input  logic            locked_i,
  input  logic [N_CH-1:0] mask_i,
  output logic [N_CH-1:0] en_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign en_o[g] = mask_i[g] & ~locked_i;
  end
endmodule

// File: rtl/det_interlock.sv
module det_interlock #(
  parameter int unsigned N_CH        = 16,
  parameter int unsigned HOLD_CYCLES = 50000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            relay_closed_i,
  input  logic            ack_sw_i,
  input  logic            ack_btn_i,
  input  logic [N_CH-1:0] det_mask_i,
  output logic            ilk_o,
  output logic            led_o,
  output logic [N_CH-1:0] det_en_o
);
  logic closed_sync;
  logic closed_ok;
  logic locked;

  ilk_relay_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(relay_closed_i), .sync_o(closed_sync)
  );

  ilk_relay_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .closed_i(closed_sync), .closed_ok_o(closed_ok)
  );

  ilk_state_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .closed_sync_i(closed_sync),
    .closed_ok_i(closed_ok), .ack_i(ack_sw_i | ack_btn_i), .locked_o(locked)
  );

  ilk_out_gate #(.N_CH(N_CH)) u_gate (
    .locked_i(locked), .mask_i(det_mask_i), .en_o(det_en_o)
  );

  assign ilk_o = locked;
  assign led_o = locked;
endmodule

// File: rtl/det_interlock_chk.sv
module det_interlock_chk #(
  parameter int unsigned N_CH = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_sw_i,
  input logic            ack_btn_i,
  input logic [N_CH-1:0] det_mask_i,
  input logic            ilk_o,
  input logic            led_o,
  input logic [N_CH-1:0] det_en_o,
  input logic            closed_sync_i,
  input logic            closed_ok_i
);
  assert_gate_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilk_o |-> (det_en_o == '0));

  assert_gate_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ilk_o |-> (det_en_o == det_mask_i));

  assert_clear_needs_close_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ilk_o) |-> $past(closed_ok_i));

  assert_clear_needs_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ilk_o) |-> $past(ack_sw_i || ack_btn_i));

  assert_open_locks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !closed_sync_i |=> ilk_o);

  assert_led_tracks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == ilk_o);
endmodule

bind det_interlock det_interlock_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_sw_i(ack_sw_i), .ack_btn_i(ack_btn_i),
  .det_mask_i(det_mask_i), .ilk_o(ilk_o), .led_o(led_o), .det_en_o(det_en_o),
  .closed_sync_i(closed_sync), .closed_ok_i(closed_ok)
);

// File: tb/det_interlock_tb.sv
`timescale 1ns/1ps
module det_interlock_tb;
  localparam int N_CH = 16;
  localparam int HOLD = 20;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            relay_closed_i = 1'b0;
  logic            ack_sw_i = 1'b0;
  logic            ack_btn_i = 1'b0;
  logic [N_CH-1:0] det_mask_i = '1;
  logic            ilk_o, led_o;
  logic [N_CH-1:0] det_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  det_interlock #(.N_CH(N_CH), .HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .relay_closed_i(relay_closed_i),
    .ack_sw_i(ack_sw_i), .ack_btn_i(ack_btn_i), .det_mask_i(det_mask_i),
    .ilk_o(ilk_o), .led_o(led_o), .det_en_o(det_en_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_sw();
    ack_sw_i = 1'b1; @(negedge clk_i); ack_sw_i = 1'b0;
  endtask

  task automatic pulse_btn();
    ack_btn_i = 1'b1; @(negedge clk_i); ack_btn_i = 1'b0;
  endtask

  // expected gating for current state
  task automatic sweep(string req, logic lock_exp);
    logic [N_CH-1:0] lf = 16'hACE1;
    for (int i = 0; i < N_CH; i++) begin
      det_mask_i = N_CH'(1) << i;
      #1 chk(req, 32'(det_en_o), lock_exp ? 32'h0 : 32'(det_mask_i));
    end
    for (int i = 0; i < 24; i++) begin
      lf = {lf[N_CH-2:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      det_mask_i = lf;
      #1 chk(req, 32'(det_en_o), lock_exp ? 32'h0 : 32'(det_mask_i));
    end
    det_mask_i = '1;
    #1 chk(req, 32'(det_en_o), lock_exp ? 32'h0 : 32'hFFFF);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 ilk", 32'(ilk_o), 1);
    chk("R1 led", 32'(led_o), 1);
    chk("R1 en", 32'(det_en_o), 0);
    sweep("R2 locked at reset", 1'b1);

    // R4 ack with relay open
    pulse_sw(); chk("R4 sw ack open", 32'(ilk_o), 1);
    pulse_btn(); chk("R4 btn ack open", 32'(ilk_o), 1);
    cyc(HOLD + 10);
    pulse_sw(); chk("R4 late ack open", 32'(ilk_o), 1);

    // R5 early ack ignored and not remembered
    relay_closed_i = 1'b1;
    cyc(5);
    pulse_sw(); chk("R5 early sw ack", 32'(ilk_o), 1);
    pulse_btn(); chk("R5 early btn ack", 32'(ilk_o), 1);
    cyc(HOLD + 10);
    chk("R5 no remembered ack", 32'(ilk_o), 1);
    chk("R10 led locked", 32'(led_o), 1);

    // R6 software ack after qualification
    pulse_sw();
    chk("R6 sw ack clears", 32'(ilk_o), 0);
    chk("R10 led clear", 32'(led_o), 0);
    sweep("R3 unlocked pass", 1'b0);

    // R8 opening re-locks within three edges
    det_mask_i = 16'h5A3C;
    relay_closed_i = 1'b0;
    cyc(3);
    chk("R8 open locks", 32'(ilk_o), 1);
    chk("R2 en low on open", 32'(det_en_o), 0);
    sweep("R2 locked sweep", 1'b1);
    det_mask_i = 16'h5A3C;
    relay_closed_i = 1'b1;
    cyc(HOLD + 10);
    chk("R8 reclose needs ack", 32'(ilk_o), 1);
    chk("R8 en low", 32'(det_en_o), 0);

    // R7 button ack, R9 mask restored
    pulse_btn();
    chk("R7 btn ack clears", 32'(ilk_o), 0);
    #1 chk("R9 mask restored", 32'(det_en_o), 32'h5A3C);

    // R8 single-clock opening
    @(negedge clk_i);
    relay_closed_i = 1'b0; @(negedge clk_i); relay_closed_i = 1'b1;
    cyc(3);
    chk("R8 glitch locks", 32'(ilk_o), 1);
    cyc(2);
    pulse_sw(); chk("R5 hold restarts", 32'(ilk_o), 1);
    cyc(HOLD + 10);
    chk("R8 glitch needs ack", 32'(ilk_o), 1);
    pulse_sw();
    chk("R6 ack after glitch", 32'(ilk_o), 0);
    #1 chk("R9 mask after glitch", 32'(det_en_o), 32'h5A3C);
    chk("R10 led after glitch", 32'(led_o), 0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule